// File: doc/BRIEF.md
# Thermistor Resistance Tracker with Thermal Shutdown and Dim Derating

This block closes a digital tracking loop around an external thermistor. It drives an 8-bit code into a current DAC that feeds the thermistor and its series resistor. A comparator reports whether the pin voltage sits above the fixed reference. The block then moves the code one step down or up, so that the code follows the conductance of the network. A higher code means a lower resistance and a hotter board. Because the code is roughly proportional to conductance, a hot board maps to a high code.

Two first-order low-pass filters follow the code. A fast one feeds a hysteretic thermal shutdown. A slow one, with a time constant of about two minutes at the default setting, scales the requested dim level down linearly as the board warms.

After reset the block runs a fast acquisition, stepping on a fast tick. It holds the power stages off until the code reports a temperature below the release point. It then tracks slowly, one step every seventh half line-cycle. The analog DAC and comparator are outside the block.

The controller has four states:
- ACQUIRE: fast stepping for a fixed number of ticks, filters preloaded.
- GATE: fast stepping, waiting for a cool reading.
- RUN: slow tracking, outputs active.
- TRIP: slow tracking, shutdown asserted.

Transitions:
- ACQUIRE to GATE when the tick window has elapsed.
- GATE to RUN when the code is below the release code.
- RUN to TRIP when the shutdown filter reaches the trip code.
- TRIP to RUN when the shutdown filter falls below the release code.

Top module: `ntc_track_derate`

## Requirements
- R1: After reset, dac_code is 0, ready and shutdown are 0, and dim_out is 0.
- R2: While ready is low, the code moves by exactly one on each cycle with fast_tick high: down when cmp_above is 1, up when it is 0. A half_cycle strobe does not move the code in this phase.
- R3: The code saturates: it stays at 0 when told to go down and at 255 when told to go up.
- R4: ready stays low until 300 fast ticks (default ACQ_TICKS) have elapsed and the code is below the release code 220. ready rises on the clock after both conditions hold, and dim_out is 0 while ready is low.
- R5: While ready is high, fast_tick has no effect. The code changes by exactly one on every seventh half_cycle strobe and on no other strobe.
- R6: In RUN, the state goes to TRIP once the shutdown-filtered code reaches 246. In TRIP, shutdown is 1, ready stays 1 and tracking continues. A filtered code of 243 does not trip.
- R7: Shutdown is not latched. It stays 1 while the filtered code is 220 or more, and clears once the filtered code drops below 220.
- R8: With the slow-filtered code d, the gain g in units of 1/256 is:
  - 256 when d is at most 197;
  - 128 when d is at least 242;
  - otherwise 256 - (((d-197)*728) >> 8).

  While ready is high, dim_out = (dim_in * g) >> 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | 1 | 1 when the thermistor pin voltage is above the reference |
| half_cycle | input | 1 | One-cycle strobe per half line-cycle |
| fast_tick | input | 1 | One-cycle strobe paced for fast acquisition |
| dim_in | input | 8 | Requested dim level |
| dac_code | output | 8 | Current DAC code (tracks conductance) |
| dim_out | output | 8 | Derated dim level, 0 until ready |
| shutdown | output | 1 | Thermal shutdown, non-latched |
| ready | output | 1 | Startup temperature gate passed; power stages may run |

## Verification
The hardest situation to reach from the ports is the hysteresis band in TRIP. There the filtered code must sit between the release and trip codes while the loop keeps tracking downward, and it only gets there after hundreds of slow half-cycle steps.

The bench closes the loop with a behavioural thermistor model. The comparator output is derived from the live code against a target that the tests move. The target rises past the trip code and then falls back, and shutdown is sampled at the moment the code crosses 230 on the way down.

The seventh-strobe spacing is checked by first strobing until the code moves. This aligns to the divider phase, after which the step spacing is counted.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

    typedef enum logic [1:0] {
        ST_ACQUIRE,
        ST_GATE,
        ST_RUN,
        ST_TRIP
    } ntc_state_t;

endpackage

// File: rtl/ntc_code_stepper.sv
module ntc_code_stepper #(
    parameter int CODE_W = 8,
    parameter int DIV    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic              fast_tick,
    input  logic              half_cycle,
    input  logic              cmp_above,
    output logic [CODE_W-1:0] code
);
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [DIV_W-1:0] div_cnt;
    logic             slow_hit;
    logic             step_en;

    assign slow_hit = half_cycle && (div_cnt == DIV_W'(DIV - 1));
    assign step_en  = fast_mode ? fast_tick : slow_hit;

    // divider is held at phase zero during fast acquisition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (fast_mode) begin
            div_cnt <= '0;
        end else if (half_cycle) begin
            if (div_cnt == DIV_W'(DIV - 1)) div_cnt <= '0;
            else                            div_cnt <= div_cnt + 1'b1;
        end
    end

    // voltage above reference means too much current: step down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else if (step_en) begin
            if (cmp_above) begin
                if (code != '0) code <= code - 1'b1;
            end else begin
                if (code != CODE_MAX) code <= code + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ntc_iir_lpf.sv
module ntc_iir_lpf #(
    parameter int W     = 8,
    parameter int SHIFT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preload,
    input  logic         update,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // one extra fraction bit keeps the rounded output exact once settled
    localparam int F  = SHIFT + 1;
    localparam int AW = W + F;

    logic [AW-1:0]        acc;
    logic [AW-1:0]        target;
    logic signed [AW+1:0] diff;
    logic signed [AW+1:0] step;
    logic signed [AW+1:0] sum;
    logic [AW:0]          rnd;

    assign target = {din, {F{1'b0}}};
    assign diff   = $signed({2'b00, target}) - $signed({2'b00, acc});
    assign step   = diff >>> SHIFT;
    assign sum    = $signed({2'b00, acc}) + step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc <= '0;
        else if (preload) acc <= target;
        else if (update)  acc <= sum[AW-1:0];
    end

    assign rnd  = {1'b0, acc} + (AW+1)'(1 << (F - 1));
    assign dout = rnd[AW] ? '1 : rnd[AW-1:F];
endmodule

// File: rtl/ntc_derate.sv
module ntc_derate #(
    parameter int CODE_W = 8,
    parameter int DIM_W  = 8,
    parameter int LO     = 197,
    parameter int HI     = 242
) (
    input  logic [CODE_W-1:0] temp,
    input  logic [DIM_W-1:0]  dim_in,
    input  logic              enable,
    output logic [DIM_W-1:0]  dim_out
);
    localparam int GQ    = 8;
    localparam int SPAN  = HI - LO;
    localparam int KQ    = ((1 << (GQ - 1)) * (1 << GQ) + SPAN / 2) / SPAN;
    localparam int PW    = CODE_W + 16;
    localparam int GW    = GQ + 1;

    logic [CODE_W-1:0]   off;
    logic [PW-1:0]       prod;
    logic [PW-1:0]       prod_q;
    logic [GW-1:0]       gain;
    logic [DIM_W+GW-1:0] scaled;

    assign off    = temp - CODE_W'(LO);
    assign prod   = PW'(off) * PW'(KQ);
    assign prod_q = prod >> GQ;

    always_comb begin
        if (temp <= CODE_W'(LO))      gain = GW'(1 << GQ);
        else if (temp >= CODE_W'(HI)) gain = GW'(1 << (GQ - 1));
        else                          gain = GW'(1 << GQ) - prod_q[GW-1:0];
    end

    assign scaled  = (DIM_W+GW)'(dim_in) * (DIM_W+GW)'(gain);
    assign dim_out = enable ? scaled[DIM_W+GQ-1:GQ] : '0;
endmodule

// File: rtl/ntc_track_derate.sv
module ntc_track_derate
    import ntc_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int DIM_W      = 8,
    parameter int STEP_DIV   = 7,
    parameter int ACQ_TICKS  = 300,
    parameter int SD_SHIFT   = 2,
    parameter int DR_SHIFT   = 14,
    parameter int TRIP_CODE  = 246,
    parameter int CLEAR_CODE = 220,
    parameter int DR_LO_CODE = 197,
    parameter int DR_HI_CODE = 242
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_above,
    input  logic              half_cycle,
    input  logic              fast_tick,
    input  logic [DIM_W-1:0]  dim_in,
    output logic [CODE_W-1:0] dac_code,
    output logic [DIM_W-1:0]  dim_out,
    output logic              shutdown,
    output logic              ready
);
    localparam int ACQ_W = $clog2(ACQ_TICKS + 1);

    ntc_state_t        state, state_nx;
    logic [ACQ_W-1:0]  acq_cnt;
    logic              acq_done;
    logic              fast_mode;
    logic [CODE_W-1:0] sd_filt;
    logic [CODE_W-1:0] dr_filt;

    assign acq_done = (acq_cnt == ACQ_W'(ACQ_TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          acq_cnt <= '0;
        else if (state == ST_ACQUIRE && fast_tick && !acq_done) acq_cnt <= acq_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACQUIRE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACQUIRE: if (acq_done)                          state_nx = ST_GATE;
            ST_GATE:    if (dac_code < CODE_W'(CLEAR_CODE))    state_nx = ST_RUN;
            ST_RUN:     if (sd_filt >= CODE_W'(TRIP_CODE))     state_nx = ST_TRIP;
            ST_TRIP:    if (sd_filt < CODE_W'(CLEAR_CODE))     state_nx = ST_RUN;
            default:                                           state_nx = ST_ACQUIRE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        fast_mode = 1'b0;
        ready     = 1'b0;
        shutdown  = 1'b0;
        unique case (state)
            ST_ACQUIRE: fast_mode = 1'b1;
            ST_GATE:    fast_mode = 1'b1;
            ST_RUN:     ready     = 1'b1;
            ST_TRIP: begin
                ready    = 1'b1;
                shutdown = 1'b1;
            end
            default:    fast_mode = 1'b1;
        endcase
    end

    ntc_code_stepper #(.CODE_W(CODE_W), .DIV(STEP_DIV)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_mode  (fast_mode),
        .fast_tick  (fast_tick),
        .half_cycle (half_cycle),
        .cmp_above  (cmp_above),
        .code       (dac_code)
    );

    ntc_iir_lpf #(.W(CODE_W), .SHIFT(SD_SHIFT)) u_sd_lpf (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (fast_mode),
        .update  (half_cycle),
        .din     (dac_code),
        .dout    (sd_filt)
    );

    ntc_iir_lpf #(.W(CODE_W), .SHIFT(DR_SHIFT)) u_dr_lpf (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (fast_mode),
        .update  (half_cycle),
        .din     (dac_code),
        .dout    (dr_filt)
    );

    ntc_derate #(
        .CODE_W (CODE_W),
        .DIM_W  (DIM_W),
        .LO     (DR_LO_CODE),
        .HI     (DR_HI_CODE)
    ) u_derate (
        .temp    (dr_filt),
        .dim_in  (dim_in),
        .enable  (ready),
        .dim_out (dim_out)
    );
endmodule

// File: rtl/ntc_track_derate_chk.sv
module ntc_track_derate_chk #(
    parameter int CODE_W = 8,
    parameter int DIM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_above,
    input logic              half_cycle,
    input logic              fast_tick,
    input logic [DIM_W-1:0]  dim_in,
    input logic [CODE_W-1:0] dac_code,
    input logic [DIM_W-1:0]  dim_out,
    input logic              shutdown,
    input logic              ready
);
    localparam logic [CODE_W-1:0] CMAX = '1;

    p_acq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !fast_tick) |=> $stable(dac_code));

    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == '0 && cmp_above) |=> (dac_code == '0));

    p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == CMAX && !cmp_above) |=> (dac_code == CMAX));

    p_dim_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (dim_out == '0));

    p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !half_cycle) |=> $stable(dac_code));

    p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(dac_code) || dac_code == $past(dac_code) + 1'b1
                  || dac_code == $past(dac_code) - 1'b1));

    p_trip_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> ready);

    p_derate_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (dim_out <= dim_in && dim_out >= (dim_in >> 1)));
endmodule

bind ntc_track_derate ntc_track_derate_chk #(.CODE_W(CODE_W), .DIM_W(DIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_above  (cmp_above),
    .half_cycle (half_cycle),
    .fast_tick  (fast_tick),
    .dim_in     (dim_in),
    .dac_code   (dac_code),
    .dim_out    (dim_out),
    .shutdown   (shutdown),
    .ready      (ready)
);

// File: tb/sim_ntc_track_derate.sv
`timescale 1ns/1ps
module sim_ntc_track_derate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_cycle = 1'b0;
    logic       fast_tick = 1'b0;
    logic [7:0] dim_in = 8'd200;
    logic [7:0] dac_code;
    logic [7:0] dim_out;
    logic       shutdown;
    logic       ready;
    logic       cmp_above;

    logic       force_en = 1'b1;
    logic       force_val = 1'b1;
    int         model_t = 150;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // behavioural thermistor: voltage above reference when code exceeds target
    assign cmp_above = force_en ? force_val : (int'(dac_code) > model_t);

    ntc_track_derate #(.DR_SHIFT(3)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_above  (cmp_above),
        .half_cycle (half_cycle),
        .fast_tick  (fast_tick),
        .dim_in     (dim_in),
        .dac_code   (dac_code),
        .dim_out    (dim_out),
        .shutdown   (shutdown),
        .ready      (ready)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic int exp_dim(input int d, input int dim);
        int g;
        if (d <= 197)      g = 256;
        else if (d >= 242) g = 128;
        else               g = 256 - (((d - 197) * 728) >> 8);
        return (dim * g) >> 8;
    endfunction

    task automatic tick();
        @(negedge clk) fast_tick = 1'b1;
        @(negedge clk) fast_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic hc();
        @(negedge clk) half_cycle = 1'b1;
        @(negedge clk) half_cycle = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic move_to(input int t, input int extra);
        model_t = t;
        for (int i = 0; i < 3000 && int'(dac_code) != t; i++) hc();
        repeat (extra) hc();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 code", dac_code, 0);
        chk("R1 ready", ready, 0);
        chk("R1 shutdown", shutdown, 0);
        chk("R1 dim_out", dim_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_acq_floor();
        force_en = 1'b1; force_val = 1'b1;
        repeat (5) tick();
        chk("R3 floor", dac_code, 0);
    endtask

    task automatic t_acq_up();
        force_val = 1'b0;
        tick();
        chk("R2 fast step up", dac_code, 1);
        repeat (3) hc();
        chk("R2 half_cycle ignored", dac_code, 1);
        repeat (299) tick();
        chk("R3 ceiling", dac_code, 255);
        chk("R4 hot start not ready", ready, 0);
        chk("R4 dim held off", dim_out, 0);
    endtask

    task automatic t_gate();
        force_val = 1'b1;
        tick();
        chk("R2 fast step down", dac_code, 254);
        repeat (34) tick();
        chk("R4 code at release", dac_code, 220);
        chk("R4 not ready at 220", ready, 0);
        tick();
        chk("R4 code below release", dac_code, 219);
        chk("R4 ready", ready, 1);
    endtask

    task automatic t_divider();
        int c0;
        int moved;
        force_en = 1'b0; model_t = 150;
        c0 = dac_code;
        repeat (4) tick();
        chk("R5 fast_tick ignored", dac_code, c0);
        moved = 0;
        for (int i = 0; i < 8 && moved == 0; i++) begin
            hc();
            if (int'(dac_code) != c0) moved = 1;
        end
        chk("R5 aligned", moved, 1);
        c0 = dac_code;
        repeat (6) hc();
        chk("R5 no step within six strobes", dac_code, c0);
        hc();
        chk("R5 step on seventh", dac_code, c0 - 1);
    endtask

    task automatic t_derate();
        move_to(150, 100);
        chk("R8 no derate when cool", dim_out, 200);
        move_to(220, 100);
        chk_rng("R8 mid derate", dim_out, exp_dim(222, 200), exp_dim(219, 200));
        chk("R6 no trip at 220", shutdown, 0);
    endtask

    task automatic t_trip();
        move_to(243, 40);
        chk("R6 no trip at 243", shutdown, 0);
        move_to(250, 40);
        chk("R6 trip", shutdown, 1);
        chk("R6 ready in trip", ready, 1);
        chk("R8 full derate", dim_out, exp_dim(250, 200));
        chk_rng("R6 tracking continues", dac_code, 250, 251);
    endtask

    task automatic t_clear();
        move_to(230, 0);
        model_t = 200;
        chk("R7 held in band", shutdown, 1);
        move_to(200, 30);
        chk("R7 cleared", shutdown, 0);
        chk("R7 ready", ready, 1);
    endtask

    initial begin
        t_reset();
        t_acq_floor();
        t_acq_up();
        t_gate();
        t_divider();
        t_derate();
        t_trip();
        t_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule